// File: doc/BRIEF.md
# Auto-Incrementing Serial Register Bank

This block is the register side of a small serial slave. A bit-level front end, outside the block, turns the two-wire bus into single-cycle events: start, stop, an address byte, a received data byte and a request for a byte to transmit. The bank checks the address byte against its fixed 7-bit slave address and acknowledges it when it matches. It then handles the data phase. In a write transfer the first data byte sets the internal pointer and each later byte is stored at the pointer. In a read transfer bytes are returned from the pointer. The pointer steps after every stored or returned byte and wraps from the last location back to 00h.

The bank holds 20 byte-wide locations. Each location has its own mask of implemented bits and its own reset value. Writing the reset code 58h to location 00h returns every location to its reset value. While a selected transfer is open, the bank freezes the timekeeping logic. Increment requests that arrive during the freeze collapse into one pending increment, and that increment is released when the stop condition arrives.

Top module: `srb_bank`

## Requirements
- R1: After reset every location holds its reset value (02h reads E0h, 0Ah to 0Dh read 80h, 10h and 12h read 07h, all others 00h), the pointer is 00h and `freeze_o` is low.
- R2: The pointer increments after each stored or returned data byte, and from 13h it wraps to 00h, for both writes and reads.
- R3: The first data byte of a write transfer loads the pointer and is not stored. A value of 14h or above loads 00h.
- R4: Unimplemented bits read back as 0. The implemented-bit masks are 7Fh for 03h and 04h, 3Fh for 05h and 06h, 07h for 07h and 10h, 1Fh for 08h, 37h for 12h, and FFh for all other locations.
- R5: Storing 58h at location 00h returns all locations, 00h included, to their R1 values. The pointer still steps as usual.
- R6: An address byte whose upper seven bits equal 1101000b is acknowledged, and bit 0 selects read (1) or write (0). With any other address the bank gives no acknowledge, stores nothing, returns nothing and does not freeze until the next start.
- R7: `freeze_o` rises in the cycle after a matching address byte and falls in the cycle after stop. While it is high, `tick_o` stays low.
- R8: Any number of `tick_i` pulses during a freeze yields exactly one `tick_o` pulse, in the cycle after stop. Outside a freeze, each `tick_i` pulse gives a `tick_o` pulse one cycle later.
- R9: A read transfer starts at the pointer left by the previous write or read.
- R10: Every data byte received in a selected write transfer is acknowledged. Each read request in a selected read transfer gives `rd_valid_o` and the byte at the pointer one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_start_i | input | 1 | Start or repeated start seen |
| ev_stop_i | input | 1 | Stop seen |
| ev_addr_i | input | 1 | `byte_i` holds an address byte |
| ev_wr_i | input | 1 | `byte_i` holds a received data byte |
| ev_rd_i | input | 1 | Front end requests a byte to transmit |
| byte_i | input | 8 | Received byte |
| tick_i | input | 1 | Timekeeping increment due |
| ack_o | output | 1 | Acknowledge for the previous byte event |
| rd_data_o | output | 8 | Byte to transmit |
| rd_valid_o | output | 1 | `rd_data_o` answers the previous read request |
| freeze_o | output | 1 | Timekeeping counters held |
| tick_o | output | 1 | Increment applied to the timekeeping counters |
| soft_rst_o | output | 1 | Reset code detected, one-cycle pulse |

## Verification
If the pointer goes wrong, the wrong byte appears on `rd_data_o` at the very next read request, so a write burst followed by a read-back exposes it within one transfer. A session flag stuck in the wrong state shows up as a missing or extra `ack_o` one cycle after the byte in question. A lost or duplicated pending increment shows up as a wrong count of `tick_o` pulses in the cycle after stop. A wrong mask or reset value shows up at the first read of the affected location.

// File: rtl/srb_pkg.sv
package srb_pkg;
   localparam int BYTE_W = 8;

   function automatic logic [BYTE_W-1:0] reg_mask(input int idx);
      case (idx)
         3, 4:    return 8'h7F;
         5, 6:    return 8'h3F;
         7, 16:   return 8'h07;
         8:       return 8'h1F;
         18:      return 8'h37;
         default: return 8'hFF;
      endcase
   endfunction

   function automatic logic [BYTE_W-1:0] reg_default(input int idx);
      case (idx)
         2:                return 8'hE0;
         10, 11, 12, 13:   return 8'h80;
         16, 18:           return 8'h07;
         default:          return 8'h00;
      endcase
   endfunction
endpackage

// File: rtl/srb_pointer.sv
module srb_pointer #(
   parameter int NUM_REGS = 20,
   localparam int PTR_W = $clog2(NUM_REGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [7:0]       load_val_i,
   input  logic             step_i,
   output logic [PTR_W-1:0] ptr_o
);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_REGS - 1);

   logic [PTR_W-1:0] ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (load_i) begin
         ptr_q <= (int'(load_val_i) >= NUM_REGS) ? '0 : load_val_i[PTR_W-1:0];
      end else if (step_i) begin
         ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
      end
   end

   assign ptr_o = ptr_q;

   a_r2_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
      int'(ptr_q) < NUM_REGS);
   a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i && ptr_q == LAST) |=> ptr_q == '0);
endmodule

// File: rtl/srb_session.sv
module srb_session #(
   parameter logic [6:0] SLAVE_ADDR = 7'b1101000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ev_start_i,
   input  logic       ev_stop_i,
   input  logic       ev_addr_i,
   input  logic       ev_wr_i,
   input  logic       ev_rd_i,
   input  logic [7:0] byte_i,
   input  logic       tick_i,
   output logic       ptr_load_o,
   output logic       reg_we_o,
   output logic       reg_re_o,
   output logic       ack_o,
   output logic       freeze_o,
   output logic       tick_o
);
   logic sel_q, rd_dir_q, first_q, freeze_q, pend_q, ack_q, tick_q;
   logic match, release_w, wr_phase;

   assign match     = (byte_i[7:1] == SLAVE_ADDR);
   assign release_w = freeze_q & ev_stop_i;
   assign wr_phase  = ev_wr_i & sel_q & ~rd_dir_q;

   assign ptr_load_o = wr_phase & first_q;
   assign reg_we_o   = wr_phase & ~first_q;
   assign reg_re_o   = ev_rd_i & sel_q & rd_dir_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q    <= 1'b0;
         rd_dir_q <= 1'b0;
         first_q  <= 1'b0;
         freeze_q <= 1'b0;
         pend_q   <= 1'b0;
         ack_q    <= 1'b0;
         tick_q   <= 1'b0;
      end else begin
         ack_q <= (ev_addr_i & match) | wr_phase;
         if (ev_stop_i) begin
            sel_q    <= 1'b0;
            first_q  <= 1'b0;
            freeze_q <= 1'b0;
         end else if (ev_start_i) begin
            sel_q <= 1'b0;
         end else if (ev_addr_i) begin
            sel_q    <= match;
            rd_dir_q <= byte_i[0];
            first_q  <= match & ~byte_i[0];
            if (match) freeze_q <= 1'b1;
         end else if (ptr_load_o) begin
            first_q <= 1'b0;
         end
         tick_q <= freeze_q ? (release_w & (pend_q | tick_i)) : tick_i;
         if (release_w)             pend_q <= 1'b0;
         else if (freeze_q & tick_i) pend_q <= 1'b1;
      end
   end

   assign ack_o    = ack_q;
   assign freeze_o = freeze_q;
   assign tick_o   = tick_q;

   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze_q && !ev_stop_i) |=> !tick_o);
   a_r7_freeze_src: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(freeze_o) |-> $past(ev_addr_i));
   a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
      (release_w && pend_q) |=> tick_o);
   a_r10_ack_src: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> $past(ev_addr_i || ev_wr_i));
endmodule

// File: rtl/srb_regfile.sv
module srb_regfile
   import srb_pkg::*;
#(
   parameter int NUM_REGS = 20,
   parameter int RESET_REG = 0,
   localparam int PTR_W = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              srst_i,
   input  logic              we_i,
   input  logic [PTR_W-1:0]  waddr_i,
   input  logic [BYTE_W-1:0] wdata_i,
   output logic [BYTE_W-1:0] q_o [NUM_REGS]
);
   for (genvar g = 0; g < NUM_REGS; g++) begin : g_loc
      localparam logic [BYTE_W-1:0] MASK = reg_mask(g);
      localparam logic [BYTE_W-1:0] DEF  = reg_default(g);
      logic [BYTE_W-1:0] val_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                val_q <= DEF;
         else if (srst_i)                           val_q <= DEF;
         else if (we_i && waddr_i == PTR_W'(g))     val_q <= wdata_i & MASK;
      end

      assign q_o[g] = val_q;
   end

   a_r5_srst: assert property (@(posedge clk) disable iff (!rst_n)
      srst_i |=> (q_o[RESET_REG] == reg_default(RESET_REG)) && (q_o[2] == reg_default(2)));
endmodule

// File: rtl/srb_bank.sv
module srb_bank
   import srb_pkg::*;
#(
   parameter int         NUM_REGS   = 20,
   parameter logic [6:0] SLAVE_ADDR = 7'b1101000,
   parameter int         RESET_REG  = 0,
   parameter logic [7:0] RESET_CODE = 8'h58
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ev_start_i,
   input  logic       ev_stop_i,
   input  logic       ev_addr_i,
   input  logic       ev_wr_i,
   input  logic       ev_rd_i,
   input  logic [7:0] byte_i,
   input  logic       tick_i,
   output logic       ack_o,
   output logic [7:0] rd_data_o,
   output logic       rd_valid_o,
   output logic       freeze_o,
   output logic       tick_o,
   output logic       soft_rst_o
);
   localparam int PTR_W = $clog2(NUM_REGS);

   if (NUM_REGS < 2 || NUM_REGS > 256) begin : g_bad_depth
      $error("NUM_REGS out of range");
   end
   if (RESET_REG >= NUM_REGS) begin : g_bad_rst
      $error("RESET_REG beyond the map");
   end

   logic              ptr_load, reg_we, reg_re, srst;
   logic [PTR_W-1:0]  ptr;
   logic [BYTE_W-1:0] regs [NUM_REGS];
   logic [BYTE_W-1:0] rd_q;
   logic              rd_v_q, srst_q;

   srb_session #(.SLAVE_ADDR(SLAVE_ADDR)) i_session (
      .clk(clk), .rst_n(rst_n),
      .ev_start_i(ev_start_i), .ev_stop_i(ev_stop_i), .ev_addr_i(ev_addr_i),
      .ev_wr_i(ev_wr_i), .ev_rd_i(ev_rd_i), .byte_i(byte_i), .tick_i(tick_i),
      .ptr_load_o(ptr_load), .reg_we_o(reg_we), .reg_re_o(reg_re),
      .ack_o(ack_o), .freeze_o(freeze_o), .tick_o(tick_o)
   );

   srb_pointer #(.NUM_REGS(NUM_REGS)) i_pointer (
      .clk(clk), .rst_n(rst_n),
      .load_i(ptr_load), .load_val_i(byte_i),
      .step_i(reg_we | reg_re), .ptr_o(ptr)
   );

   assign srst = reg_we && (ptr == PTR_W'(RESET_REG)) && (byte_i == RESET_CODE);

   srb_regfile #(.NUM_REGS(NUM_REGS), .RESET_REG(RESET_REG)) i_regfile (
      .clk(clk), .rst_n(rst_n), .srst_i(srst),
      .we_i(reg_we), .waddr_i(ptr), .wdata_i(byte_i), .q_o(regs)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q   <= '0;
         rd_v_q <= 1'b0;
         srst_q <= 1'b0;
      end else begin
         rd_v_q <= reg_re;
         srst_q <= srst;
         if (reg_re) rd_q <= regs[ptr];
      end
   end

   assign rd_data_o  = rd_q;
   assign rd_valid_o = rd_v_q;
   assign soft_rst_o = srst_q;

   a_r10_rd_src: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_o |-> $past(ev_rd_i));
   a_r6_no_sel_no_rd: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_rd_i && !freeze_o) |=> !rd_valid_o);
endmodule

// File: tb/test_srb_bank.sv
module test_srb_bank;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ev_start = 0, ev_stop = 0, ev_addr = 0, ev_wr = 0, ev_rd = 0, tick_in = 0;
   logic [7:0] byte_in = '0;
   logic ack, rd_valid, freeze, tick_out, soft_rst;
   logic [7:0] rd_data;
   int checks = 0, fails = 0, tick_cnt = 0;

   always #5 clk = ~clk;

   srb_bank i_srb_bank (
      .clk(clk), .rst_n(rst_n),
      .ev_start_i(ev_start), .ev_stop_i(ev_stop), .ev_addr_i(ev_addr),
      .ev_wr_i(ev_wr), .ev_rd_i(ev_rd), .byte_i(byte_in), .tick_i(tick_in),
      .ack_o(ack), .rd_data_o(rd_data), .rd_valid_o(rd_valid),
      .freeze_o(freeze), .tick_o(tick_out), .soft_rst_o(soft_rst)
   );

   always @(negedge clk) if (tick_out) tick_cnt++;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // one-cycle event; outputs are sampled at the following falling edge
   task automatic pulse(input int kind, input logic [7:0] b);
      @(negedge clk);
      byte_in = b;
      case (kind)
         0: ev_start = 1; 1: ev_stop = 1; 2: ev_addr = 1;
         3: ev_wr = 1;    4: ev_rd = 1;   default: tick_in = 1;
      endcase
      @(negedge clk);
      {ev_start, ev_stop, ev_addr, ev_wr, ev_rd, tick_in} = '0;
   endtask

   task automatic open_tx(input logic rd, input string req);
      pulse(0, 0);
      pulse(2, {7'b1101000, rd});
      chk(req, ack, 1);
   endtask

   task automatic wr_byte(input logic [7:0] b, input string req);
      pulse(3, b);
      chk(req, ack, 1);
   endtask

   task automatic rd_expect(input logic [7:0] exp, input string req);
      pulse(4, 0);
      chk({req, " valid"}, rd_valid, 1);
      chk(req, rd_data, exp);
   endtask

   task automatic set_ptr(input logic [7:0] p);
      open_tx(0, "R6 addr ack");
      wr_byte(p, "R10 ptr ack");
      pulse(1, 0);
   endtask

   task automatic t_reset;
      chk("R1 freeze low", freeze, 0);
      open_tx(1, "R6 read addr ack");
      rd_expect(8'h00, "R1 reg00");
      rd_expect(8'h00, "R1 reg01");
      rd_expect(8'hE0, "R1 reg02");
      pulse(1, 0);
      set_ptr(8'h0B); open_tx(1, "R6"); rd_expect(8'h80, "R1 reg0B"); pulse(1, 0);
   endtask

   task automatic t_masks;
      open_tx(0, "R6");
      wr_byte(8'h05, "R3 ptr load");
      wr_byte(8'hFF, "R10 data ack");
      wr_byte(8'hFF, "R10 data ack");
      wr_byte(8'hFF, "R10 data ack");
      pulse(1, 0);
      set_ptr(8'h05);
      open_tx(1, "R6");
      rd_expect(8'h3F, "R4 reg05 mask");
      rd_expect(8'h3F, "R4 reg06 mask");
      rd_expect(8'h07, "R4 reg07 mask");
      pulse(1, 0);
      // R9: next read carries on at 08h
      open_tx(1, "R6");
      rd_expect(8'h00, "R9 continue at 08h");
      pulse(1, 0);
   endtask

   task automatic t_wrap;
      open_tx(0, "R6");
      wr_byte(8'h12, "R3");
      wr_byte(8'hAA, "R2");
      wr_byte(8'hBB, "R2");
      wr_byte(8'hCC, "R2 wrap write to 00h");
      pulse(1, 0);
      open_tx(1, "R6");
      rd_expect(8'h00, "R9 read after write at 01h");
      pulse(1, 0);
      set_ptr(8'h12);
      open_tx(1, "R6");
      rd_expect(8'h22, "R4 reg12 mask");
      rd_expect(8'hBB, "R2 reg13");
      rd_expect(8'hCC, "R2 read wrap to 00h");
      pulse(1, 0);
      set_ptr(8'h20);
      open_tx(1, "R6");
      rd_expect(8'hCC, "R3 out of range loads 00h");
      pulse(1, 0);
   endtask

   task automatic t_soft_reset;
      open_tx(0, "R6");
      wr_byte(8'h02, "R3");
      wr_byte(8'h00, "R10");
      pulse(1, 0);
      set_ptr(8'h02); open_tx(1, "R6"); rd_expect(8'h00, "R5 reg02 cleared first"); pulse(1, 0);
      open_tx(0, "R6");
      wr_byte(8'h00, "R3");
      wr_byte(8'h58, "R5 code ack");
      chk("R5 soft reset pulse", soft_rst, 1);
      pulse(1, 0);
      set_ptr(8'h00);
      open_tx(1, "R6");
      rd_expect(8'h00, "R5 reg00 default");
      rd_expect(8'h00, "R5 reg01 default");
      rd_expect(8'hE0, "R5 reg02 default");
      pulse(1, 0);
      set_ptr(8'h12); open_tx(1, "R6"); rd_expect(8'h07, "R5 reg12 default"); pulse(1, 0);
   endtask

   task automatic t_foreign;
      pulse(0, 0);
      pulse(2, 8'hA0);
      chk("R6 foreign addr nack", ack, 0);
      chk("R6 no freeze", freeze, 0);
      pulse(3, 8'h05);
      chk("R6 no ptr ack", ack, 0);
      pulse(3, 8'h77);
      chk("R6 no data ack", ack, 0);
      pulse(1, 0);
      pulse(0, 0);
      pulse(2, 8'hA1);
      pulse(4, 0);
      chk("R6 no read data", rd_valid, 0);
      pulse(1, 0);
      set_ptr(8'h05); open_tx(1, "R6"); rd_expect(8'h00, "R6 reg05 untouched"); pulse(1, 0);
   endtask

   task automatic t_freeze;
      int base;
      base = tick_cnt;
      pulse(5, 0);
      @(negedge clk);
      chk("R8 free tick passes", tick_cnt - base, 1);
      open_tx(0, "R6");
      chk("R7 freeze high", freeze, 1);
      base = tick_cnt;
      pulse(5, 0);
      pulse(5, 0);
      pulse(5, 0);
      chk("R7 no tick while frozen", tick_cnt - base, 0);
      pulse(1, 0);
      chk("R7 freeze released", freeze, 0);
      chk("R8 pending tick at release", tick_out, 1);
      repeat (3) @(negedge clk);
      chk("R8 exactly one pending tick", tick_cnt - base, 1);
      open_tx(0, "R6");
      base = tick_cnt;
      pulse(1, 0);
      repeat (2) @(negedge clk);
      chk("R8 no tick without pending", tick_cnt - base, 0);
   endtask

   initial begin
      #1ms;
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_masks();
      t_wrap();
      t_soft_reset();
      t_foreign();
      t_freeze();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule